// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block gathers three interrupt sources for a small microcontroller core and turns them into a high-priority request, a low-priority request and a sleep wake signal. The first source is an external pin with selectable edge polarity. The second is an 8/16-bit timer that raises an event when its count wraps. The third is a port change detector with a mask bit for each pin. Every source has a sticky flag and an enable bit. The timer and port-change sources also have a priority bit. The external pin has no priority bit and always counts as high priority.

Software programs the block through a write-only register port. Each write selects one of four addresses with `wr_addr_i`:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0: pin enable; bit 1: timer enable; bit 2: change enable; bit 3: timer priority; bit 4: change priority; bit 5: pin polarity (1 = rising, 0 = falling); bit 6: timer width (1 = 16-bit, 0 = 8-bit); bit 7: high global enable; bit 8: low global enable |
| 1 | flag clear | writing 1 clears a flag; bit 0 is the pin flag, bit 1 the timer flag, bit 2 the change flag |
| 2 | pin mask | one change-enable bit per port pin |
| 3 | timer load | new timer count |

`flags_o` uses the same bit order as the clear register. `tmr_cnt_o` shows the timer count.

The request arbiter is a three-state machine:
- `ARB_IDLE`: no request.
- `ARB_HIGH`: drives `irq_hi_o`.
- `ARB_LOW`: drives `irq_lo_o`.

Each clock it moves to the state the current pending set calls for. Two conditions steer it. *grant_hi* holds when the high global enable is set and an enabled, flagged source is routed high. *grant_lo* holds when both global enables are set, an enabled, flagged source is routed low, and *grant_hi* is false. The transitions are:
- `IDLE→HIGH`, `LOW→HIGH`: on grant_hi.
- `IDLE→LOW`, `HIGH→LOW`: on grant_lo.
- `HIGH→IDLE`, `LOW→IDLE`: when neither grant holds.
- Otherwise the state holds.

Top module: `irqc_top`

## Requirements
- R1: The pin flag (`flags_o` bit 0) sets on a rising pin edge when control bit 5 is 1, and on a falling edge when it is 0. An edge of the other direction leaves the flag unchanged.
- R2: A pin edge sets the pin flag even when the pin enable (control bit 0) is 0. With the enable at 0, no request follows.
- R3: Hardware only sets flags. A flag stays set until software writes 1 to its bit at address 1. When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R4: An enabled, flagged pin source always drives the high-priority request when the high global enable (control bit 7) is 1.
- R5: In 8-bit mode (control bit 6 = 0, the reset value), each tick increments only the low byte of the count. The high byte is kept. The timer flag (bit 1) sets on the low-byte wrap from FFh to 00h.
- R6: In 16-bit mode, each tick increments the full 16-bit count. The timer flag sets only on the wrap from FFFFh to 0000h.
- R7: A priority bit of 1 (control bit 3 for the timer, bit 4 for port change) routes that source to `irq_hi_o`. A priority bit of 0 routes it to `irq_lo_o`.
- R8: A change on any port pin whose mask bit (address 2) is 1 sets the shared change flag (bit 2). Changes on masked-off pins set nothing.
- R9: All pin mask bits reset to 0, so no port change sets the change flag until software enables a pin.
- R10: `irq_hi_o` requires the high global enable. `irq_lo_o` requires both global enables (bits 7 and 8) and no pending high-priority grant. The two requests are never asserted together.
- R11: `wake_o` is asserted whenever `sleep_i` is 1 and any enabled source has its flag set, whatever the global enables are.
- R12: After reset, all flags, both requests and the timer count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| port_pins_i | input | PORT_W | Port pins watched for change (asynchronous) |
| tmr_tick_i | input | 1 | Timer increment strobe |
| sleep_i | input | 1 | Core is asleep |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 control, 1 clear, 2 mask, 3 timer load) |
| wr_data_i | input | TMR_W | Register write data |
| irq_hi_o | output | 1 | High-priority request |
| irq_lo_o | output | 1 | Low-priority request |
| wake_o | output | 1 | Wake request for sleep mode |
| flags_o | output | 3 | Flags: bit 0 pin, bit 1 timer, bit 2 change |
| tmr_cnt_o | output | TMR_W | Timer count |

## Verification
Each result appears at a fixed number of clock edges after its stimulus:
- A pin or port change appears in `flags_o` three edges after it reaches the input: two synchroniser edges, then the edge that registers the comparison.
- The timer flag and the new count appear on the edge that samples the tick.
- A request follows its flag one edge later, through the arbiter state register.
- `wake_o` follows the flags and `sleep_i` without a register.

A behavioural model in the bench applies these same latencies and is compared against every output in the middle of each clock cycle. Targeted checks are made only after the longest of these latencies has passed.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int NSRC    = 3;
    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_CHG = 2;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CLR  = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;
    localparam logic [1:0] ADDR_LOAD = 2'd3;

    localparam int CTRL_W = 9;

    // Packed with the most significant field first; bit 0 is pin_en.
    typedef struct packed {
        logic gie_lo;
        logic gie_hi;
        logic tmr_wide;
        logic pin_rise;
        logic chg_prio;
        logic tmr_prio;
        logic chg_en;
        logic tmr_en;
        logic pin_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_HIGH = 2'd1,
        ARB_LOW  = 2'd2
    } arb_state_t;
endpackage

// File: rtl/irqc_edge_detect.sv
`timescale 1ns/1ps
module irqc_edge_detect #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] ref_q;

    // One two-flop synchroniser plus one reference flop for each pin.
    // The reference always updates, whether or not the pin is masked.
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                ref_q[i]  <= 1'b0;
            end else begin
                meta_q[i] <= pin_i[i];
                sync_q[i] <= meta_q[i];
                ref_q[i]  <= sync_q[i];
            end
        end
        assign rise_o[i] = sync_q[i] & ~ref_q[i];
        assign fall_o[i] = ~sync_q[i] & ref_q[i];
    end
endmodule

// File: rtl/irqc_timer.sv
`timescale 1ns/1ps
module irqc_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         wide_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    localparam int HALF = W / 2;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    always_comb begin
        if (wide_i) cnt_inc = cnt_q + 1'b1;
        else        cnt_inc = {cnt_q[W-1:HALF], cnt_q[HALF-1:0] + 1'b1};
    end

    assign ovf_o = tick_i && !load_i && (wide_i ? (&cnt_q) : (&cnt_q[HALF-1:0]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (tick_i) cnt_q <= cnt_inc;
    end

    assign cnt_o = cnt_q;

    p_wrap8_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !wide_i) |=> (cnt_q[HALF-1:0] == '0));
    p_wrap16_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && wide_i) |=> (cnt_q == '0));
endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] prio_hi_i,
    input  logic            gie_hi_i,
    input  logic            gie_lo_i,
    input  logic            sleep_i,
    output logic            irq_hi_o,
    output logic            irq_lo_o,
    output logic            wake_o
);
    arb_state_t      state_q, state_d;
    logic [NSRC-1:0] pend;
    logic            grant_hi, grant_lo;

    assign pend     = flags_i & en_i;
    assign grant_hi = gie_hi_i && |(pend & prio_hi_i);
    assign grant_lo = gie_hi_i && gie_lo_i && |(pend & ~prio_hi_i) && !grant_hi;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (grant_hi)      state_d = ARB_HIGH;
                else if (grant_lo) state_d = ARB_LOW;
            end
            ARB_HIGH: begin
                if (!grant_hi) state_d = grant_lo ? ARB_LOW : ARB_IDLE;
            end
            ARB_LOW: begin
                if (grant_hi)      state_d = ARB_HIGH;
                else if (!grant_lo) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_hi_o = (state_q == ARB_HIGH);
        irq_lo_o = (state_q == ARB_LOW);
        wake_o   = sleep_i && (|pend);
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_hi_o && irq_lo_o));
    p_hi_blocks_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hi |=> !irq_lo_o);
    p_pin_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i[SRC_EXT] && en_i[SRC_EXT] && gie_hi_i) |=> irq_hi_o);
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
    import irqc_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_i,
    input  logic [PORT_W-1:0] port_pins_i,
    input  logic              tmr_tick_i,
    input  logic              sleep_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [TMR_W-1:0]  wr_data_i,
    output logic              irq_hi_o,
    output logic              irq_lo_o,
    output logic              wake_o,
    output logic [NSRC-1:0]   flags_o,
    output logic [TMR_W-1:0]  tmr_cnt_o
);
    ctrl_t             ctrl_q;
    logic [PORT_W-1:0] mask_q;
    logic [NSRC-1:0]   flags_q;
    logic [NSRC-1:0]   set_vec, clr_vec, en_vec, prio_vec;
    logic              pin_rise, pin_fall, tmr_ovf, load;
    logic [PORT_W-1:0] port_rise, port_fall;

    irqc_edge_detect #(.W(1)) u_pin_det (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i),
        .rise_o(pin_rise), .fall_o(pin_fall)
    );

    irqc_edge_detect #(.W(PORT_W)) u_port_det (
        .clk(clk), .rst_n(rst_n), .pin_i(port_pins_i),
        .rise_o(port_rise), .fall_o(port_fall)
    );

    assign load = wr_en_i && (wr_addr_i == ADDR_LOAD);

    irqc_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tmr_tick_i), .wide_i(ctrl_q.tmr_wide),
        .load_i(load), .load_val_i(wr_data_i), .cnt_o(tmr_cnt_o), .ovf_o(tmr_ovf)
    );

    assign set_vec[SRC_EXT] = ctrl_q.pin_rise ? pin_rise : pin_fall;
    assign set_vec[SRC_TMR] = tmr_ovf;
    assign set_vec[SRC_CHG] = |((port_rise | port_fall) & mask_q);
    assign clr_vec = (wr_en_i && wr_addr_i == ADDR_CLR) ? wr_data_i[NSRC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (wr_en_i && wr_addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
            if (wr_en_i && wr_addr_i == ADDR_MASK) mask_q <= wr_data_i[PORT_W-1:0];
        end
    end

    assign en_vec   = {ctrl_q.chg_en, ctrl_q.tmr_en, ctrl_q.pin_en};
    assign prio_vec = {ctrl_q.chg_prio, ctrl_q.tmr_prio, 1'b1};

    irqc_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .flags_i(flags_q), .en_i(en_vec),
        .prio_hi_i(prio_vec), .gie_hi_i(ctrl_q.gie_hi), .gie_lo_i(ctrl_q.gie_lo),
        .sleep_i(sleep_i), .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o), .wake_o(wake_o)
    );

    assign flags_o = flags_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_sticky
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);
    end

    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !$rose(flags_q[SRC_CHG]));
endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
    localparam int PW = 4;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_pin_i = 1'b0;
    logic [PW-1:0] port_pins_i = '0;
    logic          tmr_tick_i = 1'b0;
    logic          sleep_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    wr_addr_i = '0;
    logic [TW-1:0] wr_data_i = '0;
    logic          irq_hi_o, irq_lo_o, wake_o;
    logic [2:0]    flags_o;
    logic [TW-1:0] tmr_cnt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irqc_top #(.PORT_W(PW), .TMR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i), .port_pins_i(port_pins_i),
        .tmr_tick_i(tmr_tick_i), .sleep_i(sleep_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .irq_hi_o(irq_hi_o),
        .irq_lo_o(irq_lo_o), .wake_o(wake_o), .flags_o(flags_o), .tmr_cnt_o(tmr_cnt_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model: pin history queues, integer flags and counter.
    logic          pin_hist[$];
    logic [PW-1:0] port_hist[$];
    int            m_flags, m_cnt, m_ctrl, m_mask;
    bit            m_hi, m_lo;

    always @(posedge clk) begin
        if (!rst_n) begin
            pin_hist = {1'b0, 1'b0, 1'b0};
            port_hist = {4'h0, 4'h0, 4'h0};
            m_flags = 0; m_cnt = 0; m_ctrl = 0; m_mask = 0; m_hi = 0; m_lo = 0;
        end else begin
            // pin_hist[1] is the synchronised value, pin_hist[2] the one before it.
            bit pin_ev, chg_ev, ovf, ld, wide;
            int en, ph, hp, lp, clr;
            pin_ev = m_ctrl[5] ? (pin_hist[1] && !pin_hist[2]) : (!pin_hist[1] && pin_hist[2]);
            chg_ev = ((port_hist[1] ^ port_hist[2]) & m_mask[PW-1:0]) != 0;
            ld = wr_en_i && wr_addr_i == 2'd3;
            wide = m_ctrl[6];
            ovf = tmr_tick_i && !ld && (wide ? (m_cnt == 32'hFFFF) : ((m_cnt % 256) == 255));
            en = m_ctrl & 7;
            ph = ((m_ctrl >> 2) & 6) | 1;
            hp = m_flags & en & ph;
            lp = m_flags & en & ~ph;
            m_hi = m_ctrl[7] && hp != 0;
            m_lo = m_ctrl[7] && m_ctrl[8] && lp != 0 && !m_hi;
            clr = (wr_en_i && wr_addr_i == 2'd1) ? int'(wr_data_i) & 7 : 0;
            m_flags = (m_flags & ~clr) | (chg_ev ? 4 : 0) | (ovf ? 2 : 0) | (pin_ev ? 1 : 0);
            if (ld) m_cnt = int'(wr_data_i);
            else if (tmr_tick_i) m_cnt = wide ? (m_cnt + 1) % 65536
                                              : (m_cnt / 256) * 256 + ((m_cnt % 256) + 1) % 256;
            if (wr_en_i && wr_addr_i == 2'd0) m_ctrl = int'(wr_data_i) & 32'h1FF;
            if (wr_en_i && wr_addr_i == 2'd2) m_mask = int'(wr_data_i) & ((1 << PW) - 1);
            pin_hist.push_front(ext_pin_i);
            void'(pin_hist.pop_back());
            port_hist.push_front(port_pins_i);
            void'(port_hist.pop_back());
        end
        #5;
        if (rst_n && !done) begin
            chk(flags_o, m_flags, "R3 model flags");
            chk(irq_hi_o, m_hi, "R10 model high request");
            chk(irq_lo_o, m_lo, "R10 model low request");
            chk(wake_o, sleep_i && ((m_flags & m_ctrl & 7) != 0), "R11 model wake");
            chk(tmr_cnt_o, m_cnt, "R5 model count");
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [TW-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tmr_tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tmr_tick_i = 1'b0;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        done = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk(flags_o, 0, "R12 reset flags");
        chk(irq_hi_o, 0, "R12 reset high request");
        chk(irq_lo_o, 0, "R12 reset low request");
        chk(tmr_cnt_o, 0, "R12 reset count");
        port_pins_i = '1; idle(6);
        chk(flags_o[2], 0, "R9 mask reset blocks change");
        port_pins_i = '0; idle(6);

        wr(2'd0, 16'h0A1);               // pin enable, rising edge, high global
        ext_pin_i = 1'b1; idle(6);
        chk(flags_o[0], 1, "R1 rising edge sets flag");
        chk(irq_hi_o, 1, "R4 pin source drives high request");
        wr(2'd1, 16'h1); idle(3);
        chk(flags_o[0], 0, "R3 clear by write");
        chk(irq_hi_o, 0, "R3 request drops after clear");
        ext_pin_i = 1'b0; idle(6);
        chk(flags_o[0], 0, "R1 falling edge ignored in rising mode");

        wr(2'd0, 16'h080);               // pin disabled, falling edge
        ext_pin_i = 1'b1; idle(6);
        chk(flags_o[0], 0, "R1 rising edge ignored in falling mode");
        ext_pin_i = 1'b0; idle(6);
        chk(flags_o[0], 1, "R2 flag recorded while disabled");
        chk(irq_hi_o, 0, "R2 no request while disabled");
        wr(2'd1, 16'h1); idle(3);
        ext_pin_i = 1'b1; idle(6);
        // Hardware set and software clear land on the same edge.
        @(negedge clk) ext_pin_i = 1'b0;
        @(negedge clk);
        @(negedge clk) begin wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 16'h1; end
        @(negedge clk) wr_en_i = 1'b0;
        chk(flags_o[0], 1, "R3 set wins over clear");
        wr(2'd1, 16'h1);

        wr(2'd0, 16'h182);               // timer enable, priority low, both globals
        wr(2'd3, 16'h12FE);
        ticks(2); idle(2);
        chk(tmr_cnt_o, 16'h1200, "R5 8-bit wrap keeps high byte");
        chk(flags_o[1], 1, "R5 8-bit wrap sets flag");
        chk(irq_lo_o, 1, "R7 priority 0 routes low");
        chk(irq_hi_o, 0, "R7 no high request");
        wr(2'd0, 16'h18A); idle(2);
        chk(irq_hi_o, 1, "R7 priority 1 routes high");
        chk(irq_lo_o, 0, "R10 requests exclusive");

        wr(2'd1, 16'h2);
        wr(2'd0, 16'h1C2);               // 16-bit mode
        wr(2'd3, 16'h00FE);
        ticks(2); idle(2);
        chk(tmr_cnt_o, 16'h0100, "R6 carry into high byte");
        chk(flags_o[1], 0, "R6 no flag on low byte wrap");
        wr(2'd3, 16'hFFFE);
        ticks(2); idle(2);
        chk(tmr_cnt_o, 16'h0000, "R6 full wrap");
        chk(flags_o[1], 1, "R6 flag on full wrap");
        wr(2'd1, 16'h2); idle(2);

        wr(2'd2, 16'h2);                 // only pin 1 watched
        wr(2'd0, 16'h184);
        port_pins_i = 4'h1; idle(6);
        chk(flags_o[2], 0, "R8 masked pin ignored");
        port_pins_i = 4'h3; idle(6);
        chk(flags_o[2], 1, "R8 enabled pin sets flag");
        chk(irq_lo_o, 1, "R8 change routed low");

        wr(2'd0, 16'h1A5);               // add pin source, rising edge
        ext_pin_i = 1'b1; idle(6);
        chk(irq_hi_o, 1, "R10 high wins");
        chk(irq_lo_o, 0, "R10 low blocked by high");
        wr(2'd0, 16'h125); idle(3);
        chk(irq_hi_o, 0, "R10 high needs global");
        chk(irq_lo_o, 0, "R10 low needs high global");

        sleep_i = 1'b1; idle(1);
        chk(wake_o, 1, "R11 wake without globals");
        wr(2'd0, 16'h000); idle(1);
        chk(wake_o, 0, "R11 no wake when disabled");
        sleep_i = 1'b0; idle(4);

        done = 1;
        report();
    end
endmodule